// File: doc/BRIEF.md
# LED Dimming and Light-Sense I/O Port

This block is a memory-mapped output port for a small soft processor. It drives eight very bright LEDs. The pins show the contents of an LED register for only one millisecond in every sixteen, so the LEDs appear dimmer. The port also contains the time base the processor uses: a counter of clock cycles that produces one tick per millisecond, and a 32-bit millisecond count that the processor can read.

In sense mode, the same pins act as a rough light detector. Just after the display slot, every pin is driven high for a short charge burst. The pins are then released to high impedance. Software polls the readback word and watches the pin levels fall as the stored charge leaks away, and it leaks faster in brighter light. The readback word also carries the inverted switch inputs. Pin levels reach that word through a two-stage synchronizer, because the decaying inputs cross the logic threshold at arbitrary times.

The processor talks to the port through a word address, a write strobe, write data and combinational read data. The timer sits at word address 6'b110000, which is byte offset -64. The LED and switch port sits at word address 1.

Top module: `led_pwm_sense_port`

## Requirements
- R1: A cycle counter counts from 0 to CLK_HZ/TICK_HZ-1 and then wraps. The 32-bit millisecond count rises by exactly one at each wrap and is otherwise unchanged. A read at word address 6'b110000 returns the millisecond count.
- R2: The phase is bits [3:0] of the millisecond count. In phase 0 the pins drive the displayed LED value, in either mode.
- R3: With sense_en low, the pins drive 8'h00 in phases 1 to 15.
- R4: With sense_en high, the pins drive 8'hFF in phase 1 while the cycle counter is below 2**PULSE_LOG2. This covers cycle-counter bits [CYC_W-1:PULSE_LOG2] all being zero.
- R5: With sense_en high, the pins are released to high impedance during the rest of phase 1 and in phases 2 to 15.
- R6: A read at word address 1 returns a word with these fields: bits [31:16] zero, bits [15:8] the synchronized pin levels, and bits [7:0] the bitwise inverse of swi.
- R7: Bits [15:8] of the readback equal the pin levels as they stood two rising clock edges earlier.
- R8: A write at word address 1 loads io_wdata[7:0] into the LED register at the next edge. The displayed value is copied from the LED register only on the edge that starts phase 0. A write that lands on that same edge, or anywhere inside a slot, is therefore first shown in the following display slot.
- R9: While rst_n is low, the cycle counter, the millisecond count, the LED register, the displayed value and the synchronizer are cleared. The port sits in phase 0 and the pins drive 8'h00.
- R10: Reads at any other word address return zero. Writes to any other address leave the LED register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sense_en | input | 1 | Static mode select: 0 for dimming only, 1 for dimming plus light sensing |
| io_wadr | input | 6 | Word address of the I/O access |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data; only bits [7:0] are used |
| io_rdata | output | 32 | Combinational read data for io_wadr |
| swi | input | 8 | Switch inputs, active low |
| leds | inout | 8 | LED pins, driven or released |

## Verification
The hardest situation to reach from the ports is reading back a released pin. The readback must show a level that the port itself did not drive, and it must not be polluted by a half cycle of undriven or contended pins at the edges of the release window. The bench therefore drives random levels onto the pins only while the expected release window covers both the current cycle and the next one. It keeps a two-deep history of the pin levels it observed, and checks the readback only when both entries in that history were truly driven by one side. Writes are also forced onto the exact edge that opens a display slot, to show that they take effect one slot later.

// File: rtl/ledport_pkg.sv
// Shared constants and types for the LED dimming / light-sense port.
// Assumes a 32-bit processor data bus and word-granular I/O addresses.
package ledport_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned LED_W   = 8;
    localparam int unsigned SW_W    = 8;
    localparam int unsigned WADR_W  = 6;
    localparam int unsigned MS_W    = 32;
    localparam int unsigned PHASE_W = 4;

    // Word address of the millisecond timer (byte offset -64).
    localparam logic [WADR_W-1:0] WADR_TIMER = 6'b110000;
    // Word address of the LED / switch port.
    localparam logic [WADR_W-1:0] WADR_LED   = 6'd1;

    // What the LED pins are doing in a given cycle.
    typedef enum logic [1:0] {
        PIN_SHOW   = 2'd0,   // display slot: drive the shown value
        PIN_DARK   = 2'd1,   // dimming only: drive zeros
        PIN_CHARGE = 2'd2,   // sense: drive ones to charge the pins
        PIN_FLOAT  = 2'd3    // sense: release to high impedance
    } pin_mode_e;

endpackage

// File: rtl/ms_timer.sv
// Millisecond time base.
// A cycle counter wraps every CYC_PER_TICK clocks, and a millisecond count
// steps once per wrap. The low PHASE_W bits of the millisecond count form the
// display phase. slot_start is high in the last cycle before phase 0 begins.
// Assumes CYC_PER_TICK >= 2.
module ms_timer #(
    parameter int unsigned CYC_PER_TICK = 30000,
    parameter int unsigned CYC_W        = $clog2(CYC_PER_TICK),
    parameter int unsigned MS_W         = 32,
    parameter int unsigned PHASE_W      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [CYC_W-1:0]   cyc,
    output logic [MS_W-1:0]    ms,
    output logic [PHASE_W-1:0] phase,
    output logic               slot_start
);

    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_TICK - 1);

    logic tick;

    assign tick       = (cyc == CYC_LAST);
    assign phase      = ms[PHASE_W-1:0];
    assign slot_start = tick && (phase == '1);

    // Cycle counter: count up, wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)     cyc <= '0;
        else if (tick)  cyc <= '0;
        else            cyc <= cyc + 1'b1;
    end

    // Millisecond count: one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     ms <= '0;
        else if (tick)  ms <= ms + 1'b1;
    end

    p_cyc_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cyc == '0));
    p_ms_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (ms == $past(ms) + MS_W'(1)));
    p_ms_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ms));

endmodule

// File: rtl/led_drive.sv
// LED register, displayed copy and the pin-drive selector.
// The displayed copy is reloaded only as phase 0 begins, so a write never
// changes a display slot that is already under way. The pin mode is decided
// from phase, sense_en and the cycle counter; the charge burst covers cycle
// counts whose bits above PULSE_LOG2 are zero. Assumes PULSE_LOG2 < CYC_W.
module led_drive
    import ledport_pkg::*;
#(
    parameter int unsigned CYC_W      = 15,
    parameter int unsigned PULSE_LOG2 = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sense_en,
    input  logic               wr_en,
    input  logic [LED_W-1:0]   wr_data,
    input  logic               slot_start,
    input  logic [PHASE_W-1:0] phase,
    input  logic [CYC_W-1:0]   cyc,
    output logic               pin_oe,
    output logic [LED_W-1:0]   pin_val
);

    logic [LED_W-1:0] led_reg;
    logic [LED_W-1:0] shown;
    logic             charge_win;
    pin_mode_e        mode;

    assign charge_win = (cyc[CYC_W-1:PULSE_LOG2] == '0);

    // LED register: loaded by a processor write.
    always_ff @(posedge clk) begin
        if (!rst_n)      led_reg <= '0;
        else if (wr_en)  led_reg <= wr_data;
    end

    // Displayed copy: refreshed on the edge that opens the display slot.
    always_ff @(posedge clk) begin
        if (!rst_n)           shown <= '0;
        else if (slot_start)  shown <= led_reg;
    end

    // Choose what the pins do in this cycle.
    always_comb begin
        if (phase == '0)                          mode = PIN_SHOW;
        else if (!sense_en)                       mode = PIN_DARK;
        else if ((phase == PHASE_W'(1)) && charge_win) mode = PIN_CHARGE;
        else                                      mode = PIN_FLOAT;
    end

    // Turn the mode into output enable and output value.
    always_comb begin
        unique case (mode)
            PIN_SHOW:   begin pin_oe = 1'b1; pin_val = shown; end
            PIN_DARK:   begin pin_oe = 1'b1; pin_val = '0;    end
            PIN_CHARGE: begin pin_oe = 1'b1; pin_val = '1;    end
            default:    begin pin_oe = 1'b0; pin_val = '0;    end
        endcase
    end

    p_show_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_start |=> $stable(shown));
    p_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_en && (phase != '0)) |-> (pin_oe && (pin_val == '0)));
    p_charge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_en && (phase == PHASE_W'(1)) && (cyc == '0)) |-> (pin_oe && (pin_val == '1)));
    p_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_en && (phase > PHASE_W'(1))) |-> !pin_oe);

endmodule

// File: rtl/pin_sync.sv
// Two-stage synchronizer for asynchronous pin levels.
// The output follows the input two rising edges later. Each bit is
// synchronized on its own; no relation between bits is kept.
module pin_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1;

    // First stage: capture the raw pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) stage1 <= '0;
        else        stage1 <= async_in;
    end

    // Second stage: resolve before use.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_out <= '0;
        else        sync_out <= stage1;
    end

endmodule

// File: rtl/led_pwm_sense_port.sv
// LED dimming and light-sense I/O port (top level).
// Combines the millisecond time base, the LED drive selector, the tri-state
// pins and the readback word. The read data is combinational on io_wadr.
// Assumes CLK_HZ is a multiple of TICK_HZ and PULSE_LOG2 < CYC_W.
module led_pwm_sense_port
    import ledport_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 30_000_000,
    parameter int unsigned TICK_HZ    = 1000,
    parameter int unsigned PULSE_LOG2 = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sense_en,
    input  logic [WADR_W-1:0]   io_wadr,
    input  logic                io_wr,
    input  logic [DATA_W-1:0]   io_wdata,
    output logic [DATA_W-1:0]   io_rdata,
    input  logic [SW_W-1:0]     swi,
    inout  wire  [LED_W-1:0]    leds
);

    localparam int unsigned CYC_PER_TICK = CLK_HZ / TICK_HZ;
    localparam int unsigned CYC_W        = $clog2(CYC_PER_TICK);
    localparam int unsigned PAD_W        = DATA_W - LED_W - SW_W;

    logic [CYC_W-1:0]   cyc;
    logic [MS_W-1:0]    ms;
    logic [PHASE_W-1:0] phase;
    logic               slot_start;
    logic               pin_oe;
    logic [LED_W-1:0]   pin_val;
    logic [LED_W-1:0]   pin_level;
    logic               led_wr;
    logic               unused_wdata;

    assign unused_wdata = ^io_wdata[DATA_W-1:LED_W];
    assign led_wr       = io_wr && (io_wadr == WADR_LED);

    ms_timer #(
        .CYC_PER_TICK (CYC_PER_TICK),
        .CYC_W        (CYC_W),
        .MS_W         (MS_W),
        .PHASE_W      (PHASE_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc        (cyc),
        .ms         (ms),
        .phase      (phase),
        .slot_start (slot_start)
    );

    led_drive #(
        .CYC_W      (CYC_W),
        .PULSE_LOG2 (PULSE_LOG2)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .sense_en   (sense_en),
        .wr_en      (led_wr),
        .wr_data    (io_wdata[LED_W-1:0]),
        .slot_start (slot_start),
        .phase      (phase),
        .cyc        (cyc),
        .pin_oe     (pin_oe),
        .pin_val    (pin_val)
    );

    // Tri-state pin driver.
    assign leds = pin_oe ? pin_val : {LED_W{1'bz}};

    pin_sync #(
        .W (LED_W)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (leds),
        .sync_out (pin_level)
    );

    // Readback selection by word address.
    always_comb begin
        io_rdata = '0;
        if (io_wadr == WADR_LED)        io_rdata = {{PAD_W{1'b0}}, pin_level, ~swi};
        else if (io_wadr == WADR_TIMER) io_rdata = DATA_W'(ms);
    end

    p_phase0_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0) |-> pin_oe);

endmodule

// File: tb/led_pwm_sense_port_test.sv
// Self-checking bench: random accesses, random switch and pin levels, with
// writes forced onto slot boundaries. Time is scaled to 256 cycles per ms.
module led_pwm_sense_port_test;
    import ledport_pkg::*;

    localparam int unsigned N    = 256;        // cycles per millisecond
    localparam int unsigned PL   = 3;          // charge burst = 8 cycles
    localparam int unsigned SLOT = 16 * N;     // cycles per display period

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n    = 1'b0;
    logic        sense_en = 1'b0;
    logic [5:0]  io_wadr  = WADR_TIMER;
    logic        io_wr    = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic [7:0]  swi      = '0;
    wire  [7:0]  leds;
    logic        inj_en   = 1'b0;
    logic [7:0]  inj_val  = '0;

    assign leds = inj_en ? inj_val : 8'bz;

    led_pwm_sense_port #(
        .CLK_HZ     (N * 1000),
        .TICK_HZ    (1000),
        .PULSE_LOG2 (PL)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sense_en (sense_en),
        .io_wadr  (io_wadr),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .swi      (swi),
        .leds     (leds)
    );

    // Expected time and display value, from R1 and R8.
    int unsigned e_cnt     = 0;
    logic [7:0]  led_comm  = '0;
    logic [7:0]  disp_exp  = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            e_cnt <= 0; led_comm <= '0; disp_exp <= '0;
        end else begin
            e_cnt <= e_cnt + 1;
            if (((e_cnt + 1) % SLOT) == 0) disp_exp <= led_comm;
            if (io_wr && io_wadr == WADR_LED) led_comm <= io_wdata[7:0];
        end
    end

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    bit   edge_wr = 0;
    logic [7:0] h1 = '0, h2 = '0;
    logic       h1v = 1'b0, h2v = 1'b0;

    // {drive enable, value} the pins should carry after e edges (R2-R5).
    function automatic logic [8:0] exp_pin(int unsigned e, logic s, logic [7:0] d);
        int unsigned ph = (e / N) % 16;
        int unsigned cy = e % N;
        if (ph == 0) return {1'b1, d};
        if (!s) return {1'b1, 8'h00};
        if (ph == 1 && cy < (1 << PL)) return {1'b1, 8'hFF};
        return {1'b0, 8'h00};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (e=%0d)", req, act, exp, e_cnt);
        end
    endtask

    // One clock: check outputs at the falling edge, then drive new inputs.
    task automatic step(input logic s_next);
        logic [8:0]  ex;
        logic [8:0]  ex_now;
        logic [8:0]  ex_nxt;
        int unsigned ph;
        int unsigned r;
        @(negedge clk);
        ex = exp_pin(e_cnt, sense_en, disp_exp);
        ph = (e_cnt / N) % 16;
        if (ex[8]) begin
            if (ph == 0)        check("R2 display slot", {24'b0, leds}, {24'b0, ex[7:0]});
            else if (!sense_en) check("R3 dark phase",   {24'b0, leds}, 32'h0);
            else                check("R4 charge burst", {24'b0, leds}, 32'hFF);
        end else if (inj_en) begin
            check("R5 released pins", {24'b0, leds}, {24'b0, inj_val});
        end
        if (io_wadr == WADR_LED) begin
            check("R6 switch field", {24'b0, io_rdata[7:0]}, {24'b0, ~swi});
            check("R6 upper zero", {16'b0, io_rdata[31:16]}, 32'h0);
            if (h1v && h2v) check("R7 pin field", {24'b0, io_rdata[15:8]}, {24'b0, h2});
        end else if (io_wadr == WADR_TIMER) begin
            check("R1 ms count", io_rdata, e_cnt / N);
        end else begin
            check("R10 other address", io_rdata, 32'h0);
        end
        // new inputs
        sense_en = s_next;
        io_wr    = 1'b0;
        io_wdata = $urandom;
        r = $urandom % 96;
        if (edge_wr && (e_cnt % SLOT) == SLOT - 1) begin
            io_wr = 1'b1; io_wadr = WADR_LED;          // R8 write on the slot edge
        end else if (r == 0) begin
            io_wr = 1'b1; io_wadr = WADR_LED;
        end else if (r == 1) begin
            io_wr = 1'b1; io_wadr = 6'd5;              // R10 stray write
        end else begin
            case (r % 3)
                0: io_wadr = WADR_LED;
                1: io_wadr = WADR_TIMER;
                default: io_wadr = 6'd7;
            endcase
        end
        swi     = $urandom;
        ex_now  = exp_pin(e_cnt, s_next, 8'h00);
        ex_nxt  = exp_pin(e_cnt + 1, s_next, 8'h00);
        inj_en  = s_next && !ex_now[8] && !ex_nxt[8];
        inj_val = $urandom;
        #1;
        h2 = h1; h2v = h1v;
        h1 = leds; h1v = inj_en || ex_now[8];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(10 * 190000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0000_5eed));
        // R9: state while in reset
        repeat (4) @(negedge clk);
        io_wadr = WADR_TIMER;
        #1;
        check("R9 ms cleared", io_rdata, 32'h0);
        check("R9 pins low", {24'b0, leds}, 32'h0);
        io_wadr = WADR_LED;
        #1;
        check("R9 pin field cleared", {24'b0, io_rdata[15:8]}, 32'h0);
        rst_n = 1'b1;
        // dimming only, random writes, then writes forced on slot edges
        for (int i = 0; i < 4 * SLOT; i++) step(1'b0);
        edge_wr = 1;
        for (int i = 0; i < 3 * SLOT; i++) step(1'b0);
        edge_wr = 0;
        // sensing
        for (int i = 0; i < 8 * SLOT; i++) step(1'b1);
        edge_wr = 1;
        for (int i = 0; i < 2 * SLOT; i++) step(1'b1);
        edge_wr = 0;
        // back to dimming only
        for (int i = 0; i < 2 * SLOT; i++) step(1'b0);
        finish_run();
    end

endmodule